// File: doc/BRIEF.md
# Byte-Lane Static Memory Controller Model

This block models the control side of a 16-bit-wide static memory whose strobes are all active low. A chip select, a read strobe, a write strobe and one enable per byte lane decide in each cycle whether the block is idle, reading or writing. A write stores only the byte lanes that are enabled. A read returns only the enabled lanes. Any lane that is not returned is marked as floating.

A real part has tri-state pins. This model instead gives each byte lane its own drive bit next to the data output, and it forces the bits of a floating lane to zero. The words are held in an internal array, one bank per byte lane. The array depth is a parameter. The address port is always 18 bits wide, and the array is indexed by the low address bits, so a reduced depth makes higher addresses alias onto lower ones.

Writes commit on the rising clock edge. The read path and the drive bits are combinational from the strobes, the address and the stored contents.

Top module: `sram_byte_lane`

## Requirements
- R1: With chip select low and write strobe low, every byte lane whose enable is low stores its slice of `data_i` at the addressed word on the rising clock edge. Lane 0 is bits 7:0 and lane 1 is bits 15:8.
- R2: During a write, a byte lane whose enable is high keeps its stored value.
- R3: With chip select low, read strobe low and write strobe high, `lane_drive_o[i]` equals the inverse of `lane_en_ni[i]`. Each driven lane shows the stored byte of the addressed word.
- R4: While chip select is high, no lane is driven and nothing is stored, whatever the other strobes do.
- R5: With chip select low and both read and write strobes high, no lane is driven.
- R6: A low write strobe takes priority over the read strobe. During a write no lane is driven, even if the read strobe is low.
- R7: A lane whose enable is high is never driven. When both enables are high, nothing is driven.
- R8: The bits of `data_o` that belong to an undriven lane read as zero.
- R9: The word index is the low `DEPTH_W` address bits. The remaining address bits are ignored, so addresses that differ only above bit `DEPTH_W-1` (bit 7 by default) reach the same word.
- R10: While `rst_ni` is low, no lane is driven and nothing is stored. Stored contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes commit on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset; blocks all access |
| addr_i | input | 18 | Word address |
| data_i | input | 16 | Write data |
| sel_ni | input | 1 | Chip select, active low |
| rd_en_ni | input | 1 | Read strobe, active low |
| wr_en_ni | input | 1 | Write strobe, active low |
| lane_en_ni | input | 2 | Byte-lane enables, active low; bit 0 is the low byte |
| data_o | output | 16 | Read data; undriven lanes are zero |
| lane_drive_o | output | 2 | High where a lane is driven; low means high impedance |

## Verification
The assertions assume that the strobes, the lane enables and the address change only between clock edges, so the combinational outputs are settled when they are sampled. The bench meets this by changing every input on the falling edge and checking the outputs shortly after. The assertions also assume that a floating lane is always zero, which is true only because the model has no tri-state pins. Apart from the reset directed test, reads target only addresses written earlier, so no check ever sees uninitialized array contents.

// File: rtl/sram_bl_pkg.sv
package sram_bl_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/sram_bl_decode.sv
module sram_bl_decode
  import sram_bl_pkg::*;
(
  input  logic rst_ni,
  input  logic sel_ni,
  input  logic rd_en_ni,
  input  logic wr_en_ni,
  output op_e  op_o
);
  always_comb begin
    if (!rst_ni || sel_ni) op_o = OP_IDLE;
    else if (!wr_en_ni)    op_o = OP_WRITE;  // write strobe wins over read
    else if (!rd_en_ni)    op_o = OP_READ;
    else                   op_o = OP_IDLE;
  end
endmodule

// File: rtl/sram_bl_lane.sv
module sram_bl_lane #(
  parameter int LANE_W  = 8,
  parameter int DEPTH_W = 8
) (
  input  logic               clk_i,
  input  logic               wr_i,
  input  logic [DEPTH_W-1:0] idx_i,
  input  logic [LANE_W-1:0]  d_i,
  output logic [LANE_W-1:0]  q_o
);
  localparam int DEPTH = 1 << DEPTH_W;

  logic [LANE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[idx_i] <= d_i;
  end

  assign q_o = mem_q[idx_i];
endmodule

// File: rtl/sram_bl_outgate.sv
module sram_bl_outgate #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    rd_i,
  input  logic [LANES-1:0]        lane_en_ni,
  input  logic [LANES*LANE_W-1:0] q_i,
  output logic [LANES*LANE_W-1:0] data_o,
  output logic [LANES-1:0]        drive_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign drive_o[g] = rd_i & ~lane_en_ni[g];
    assign data_o[g*LANE_W +: LANE_W] = drive_o[g] ? q_i[g*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/sram_byte_lane.sv
module sram_byte_lane
  import sram_bl_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int LANES   = 2,
  parameter int LANE_W  = 8,
  parameter int DEPTH_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] data_i,
  input  logic                    sel_ni,
  input  logic                    rd_en_ni,
  input  logic                    wr_en_ni,
  input  logic [LANES-1:0]        lane_en_ni,
  output logic [LANES*LANE_W-1:0] data_o,
  output logic [LANES-1:0]        lane_drive_o
);
  localparam int DATA_W = LANES * LANE_W;

  op_e               op;
  logic [DEPTH_W-1:0] idx;
  logic [DATA_W-1:0]  q;
  logic               unused_addr_hi;

  assign idx            = addr_i[DEPTH_W-1:0];
  assign unused_addr_hi = ^addr_i[ADDR_W-1:DEPTH_W];

  sram_bl_decode u_dec (
    .rst_ni   (rst_ni),
    .sel_ni   (sel_ni),
    .rd_en_ni (rd_en_ni),
    .wr_en_ni (wr_en_ni),
    .op_o     (op)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_bank
    logic lane_wr;
    assign lane_wr = (op == OP_WRITE) & ~lane_en_ni[g];
    sram_bl_lane #(.LANE_W(LANE_W), .DEPTH_W(DEPTH_W)) u_lane (
      .clk_i (clk_i),
      .wr_i  (lane_wr),
      .idx_i (idx),
      .d_i   (data_i[g*LANE_W +: LANE_W]),
      .q_o   (q[g*LANE_W +: LANE_W])
    );
  end

  sram_bl_outgate #(.LANES(LANES), .LANE_W(LANE_W)) u_out (
    .rd_i       (op == OP_READ),
    .lane_en_ni (lane_en_ni),
    .q_i        (q),
    .data_o     (data_o),
    .drive_o    (lane_drive_o)
  );
endmodule

// File: rtl/sram_byte_lane_chk.sv
module sram_byte_lane_chk #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    sel_ni,
  input logic                    rd_en_ni,
  input logic                    wr_en_ni,
  input logic [LANES-1:0]        lane_en_ni,
  input logic [LANES*LANE_W-1:0] data_o,
  input logic [LANES-1:0]        lane_drive_o
);
  // R4
  standby_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ni |-> lane_drive_o == '0);

  // R5
  idle_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_ni && rd_en_ni) |-> lane_drive_o == '0);

  // R6
  write_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_ni |-> lane_drive_o == '0);

  // R7
  lane_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_drive_o & lane_en_ni) == '0);

  // R3
  read_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_ni && !rd_en_ni && wr_en_ni) |-> lane_drive_o == ~lane_en_ni);

  for (genvar g = 0; g < LANES; g++) begin : g_zero
    // R8
    float_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lane_drive_o[g] |-> data_o[g*LANE_W +: LANE_W] == '0);
  end

  always @(posedge clk_i) begin
    // R10
    if (!rst_ni) reset_quiet_chk: assert (lane_drive_o == '0);
  end
endmodule

bind sram_byte_lane sram_byte_lane_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/sim_sram_byte_lane.sv
module sim_sram_byte_lane;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [17:0] addr_i = '0;
  logic [15:0] data_i = '0;
  logic        sel_ni = 1'b1;
  logic        rd_en_ni = 1'b1;
  logic        wr_en_ni = 1'b1;
  logic [1:0]  lane_en_ni = 2'b11;
  logic [15:0] data_o;
  logic [1:0]  lane_drive_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  sram_byte_lane u0 (.*);

  typedef struct packed {
    logic        s;
    logic        r;
    logic        w;
    logic [1:0]  ln;
    logic [17:0] a;
    logic [15:0] d;
    logic [1:0]  xdrv;
    logic [15:0] xdat;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b1,1'b0,2'b00,18'h00005,16'hA1B2,2'b00,16'h0000,8'd1},  // R1 write both lanes
    '{1'b0,1'b0,1'b1,2'b00,18'h00005,16'h0000,2'b11,16'hA1B2,8'd3},  // R3 read back
    '{1'b0,1'b1,1'b0,2'b10,18'h00005,16'hFFCC,2'b00,16'h0000,8'd2},  // R2 low lane only
    '{1'b0,1'b0,1'b1,2'b00,18'h00005,16'h0000,2'b11,16'hA1CC,8'd2},  // R2
    '{1'b0,1'b1,1'b0,2'b01,18'h00005,16'h3344,2'b00,16'h0000,8'd2},  // R2 high lane only
    '{1'b0,1'b0,1'b1,2'b00,18'h00005,16'h0000,2'b11,16'h33CC,8'd2},  // R2
    '{1'b0,1'b0,1'b1,2'b10,18'h00005,16'h0000,2'b01,16'h00CC,8'd7},  // R7 low lane read
    '{1'b0,1'b0,1'b1,2'b01,18'h00005,16'h0000,2'b10,16'h3300,8'd8},  // R8 high lane read
    '{1'b0,1'b0,1'b1,2'b11,18'h00005,16'h0000,2'b00,16'h0000,8'd7},  // R7 no lanes
    '{1'b0,1'b0,1'b0,2'b00,18'h00005,16'h5566,2'b00,16'h0000,8'd6},  // R6 write wins
    '{1'b0,1'b0,1'b1,2'b00,18'h00005,16'h0000,2'b11,16'h5566,8'd6},  // R6
    '{1'b1,1'b1,1'b0,2'b00,18'h00005,16'hDEAD,2'b00,16'h0000,8'd4},  // R4 standby write
    '{1'b0,1'b0,1'b1,2'b00,18'h00005,16'h0000,2'b11,16'h5566,8'd4},  // R4
    '{1'b0,1'b1,1'b1,2'b00,18'h00005,16'h0000,2'b00,16'h0000,8'd5},  // R5 no strobe
    '{1'b0,1'b1,1'b0,2'b00,18'h10007,16'h7788,2'b00,16'h0000,8'd9},  // R9 aliased write
    '{1'b0,1'b0,1'b1,2'b00,18'h00007,16'h0000,2'b11,16'h7788,8'd9},  // R9
    '{1'b0,1'b0,1'b1,2'b00,18'h3FF07,16'h0000,2'b11,16'h7788,8'd9}   // R9
  };

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic s, input logic r, input logic w,
                       input logic [1:0] ln, input logic [17:0] a, input logic [15:0] d);
    sel_ni = s; rd_en_ni = r; wr_en_ni = w; lane_en_ni = ln; addr_i = a; data_i = d;
  endtask

  initial begin
    // R10 reset state with a read requested
    drive(1'b0, 1'b0, 1'b1, 2'b00, 18'h0, 16'h0);
    #2;
    check("R10 drive in reset", {14'd0, lane_drive_o}, 16'h0000);
    check("R10 data in reset", data_o, 16'h0000);
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    drive(1'b1, 1'b1, 1'b1, 2'b11, 18'h0, 16'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      drive(TBL[i].s, TBL[i].r, TBL[i].w, TBL[i].ln, TBL[i].a, TBL[i].d);
      #2;
      check($sformatf("R%0d drive vec %0d", TBL[i].req, i), {14'd0, lane_drive_o}, {14'd0, TBL[i].xdrv});
      check($sformatf("R%0d data vec %0d", TBL[i].req, i), data_o, TBL[i].xdat);
    end

    // R10 write attempt under reset is blocked, contents kept
    @(negedge clk_i);
    rst_ni = 1'b0;
    drive(1'b0, 1'b1, 1'b0, 2'b00, 18'h00005, 16'h0000);
    #2;
    check("R10 drive during reset write", {14'd0, lane_drive_o}, 16'h0000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    drive(1'b0, 1'b0, 1'b1, 2'b00, 18'h00005, 16'h0000);
    #2;
    check("R10 data kept after reset", data_o, 16'h5566);
    check("R3 drive after reset", {14'd0, lane_drive_o}, 16'h0003);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule